// File: doc/BRIEF.md
# Programmable Asynchronous Memory Cycle Sequencer

The block drives the control strobes for single asynchronous reads and writes to an external 16-bit memory with separate address and data buses. A client hands it one request at a time over a valid/ready handshake. The request carries a chip-select index, a direction, a word address, byte enables and write data. The block then runs one access. A counter in functional-clock cycles starts at 0 on the first cycle of the access. Each strobe edge sits at a count taken from the timing set of the addressed chip select. The address and byte enables stay valid for the programmed cycle time, and when that time runs out every strobe returns to its inactive level.

Each of the eight chip selects has its own timing set: on and off counts for chip select, address valid, output enable and write enable, a read sample count, separate read and write cycle times, and an idle-gap policy. A request may be offered during the last cycle of an access. If the gap policy for the case (same or different chip select) is off, the new access begins on the very next cycle. A strobe that stays low to the end of the first access and starts at count 0 in the second access therefore never toggles. If the gap is on, all strobes stay high for the programmed number of cycles before the next access starts. For reads, the data bus is sampled at the read sample count and returned with a one-cycle valid pulse.

Top module: `async_mem_seq`

## Requirements
- R1: While reset is held and after it is released, all chip-select lines, address valid, output enable, write enable and both byte enables are high, the write-data drive enable is low, ready is high and read valid is low.
- R2: At count c of an access to chip select k, line k of the chip-select output is low exactly when cs_on <= c < cs_off. cs_off is the read-off field for reads and the write-off field for writes. The timing field of chip select k is element [k] of each timing port. All other chip-select lines stay high.
- R3: At count c, address valid is low exactly when adv_on <= c < adv_off, where adv_off is the read-off field for reads and the write-off field for writes.
- R4: At count c, output enable is low only on reads and only when oe_on <= c < oe_off. Write enable is low only on writes and only when we_on <= c < we_off. During a write the data output carries the request's write data and the drive enable is high. During a read the drive enable is low.
- R5: An access lasts L cycles, where L is the write cycle time for writes and the read cycle time for reads, and a cycle time of 0 counts as 1. For all L cycles the address output equals the request address and the byte-enable output is the inverse of the request's active-high byte enables (bit 0 is the low byte).
- R6: When an access ends and no new request was taken in its last cycle, all strobes are high and the drive enable is low in the next cycle. This holds even if an off count is larger than L.
- R7: A request accepted in the last cycle of an access with no gap starts at count 0 in the next cycle. A strobe whose off count equals L in the first access and whose on count is 0 in the second access stays low across the boundary.
- R8: A request accepted in the last cycle is preceded by G idle cycles with all strobes high and ready low. G is the gap length of the finishing access's chip select if that chip select's same-select enable (when the chip selects are equal) or different-select enable (otherwise) is set. Otherwise G is 0.
- R9: On a read with rd_acc < L, the data input present in the cycle at count rd_acc is returned on the read data output with read valid high for exactly the following cycle. Read valid is low at all other times.
- R10: Ready is high when idle and in the last cycle of an access, and low in all other cycles of an access and of a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | 3 | Chip-select index |
| req_addr_i | input | 11 | Word address |
| req_be_i | input | 2 | Byte enables, active high |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 16 | Captured read data |
| cfg_cs_on_i | input | 8x5 | Chip-select on count per select |
| cfg_cs_rd_off_i | input | 8x5 | Chip-select off count, reads |
| cfg_cs_wr_off_i | input | 8x5 | Chip-select off count, writes |
| cfg_adv_on_i | input | 8x5 | Address-valid on count |
| cfg_adv_rd_off_i | input | 8x5 | Address-valid off count, reads |
| cfg_adv_wr_off_i | input | 8x5 | Address-valid off count, writes |
| cfg_oe_on_i | input | 8x5 | Output-enable on count |
| cfg_oe_off_i | input | 8x5 | Output-enable off count |
| cfg_we_on_i | input | 8x5 | Write-enable on count |
| cfg_we_off_i | input | 8x5 | Write-enable off count |
| cfg_rd_acc_i | input | 8x5 | Read sample count |
| cfg_rd_cyc_i | input | 8x5 | Read cycle time |
| cfg_wr_cyc_i | input | 8x5 | Write cycle time |
| cfg_gap_same_i | input | 8 | Gap enable, same select follows |
| cfg_gap_diff_i | input | 8 | Gap enable, other select follows |
| cfg_gap_len_i | input | 8x4 | Gap length in cycles |
| mem_cs_no | output | 8 | Chip-select lines, active low |
| mem_adv_no | output | 1 | Address valid, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_be_no | output | 2 | Byte enables, active low |
| mem_addr_o | output | 11 | Memory address |
| mem_wdata_o | output | 16 | Write data to memory |
| mem_wdata_oe_o | output | 1 | Write-data drive enable |
| mem_rdata_i | input | 16 | Read data from memory |

## Verification
Two things can happen in the same cycle: the last cycle of one access and the acceptance of the next request. In that cycle the block must also decide between chaining the two accesses directly and inserting a gap. A read whose sample count is the last cycle can also put its valid pulse on the first cycle of the following access. The bench provokes both by offering chained requests in the last cycle of reads and writes, to the same and to other chip selects, with gap policies on and off, and with the read sample count set to the final count. It judges every cycle of each access, each gap and the idle cycle after it against windows and gap lengths computed from the programmed counts. A sweep of single accesses over on, off and cycle values, including off counts beyond the cycle time and a cycle time of 0, covers the forced deassert at the end of an access.

// File: rtl/asm_pkg.sv
package asm_pkg;
  localparam int TIME_W = 5;
  localparam int GAP_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_GAP} seq_st_e;

  typedef struct packed {
    logic [TIME_W-1:0] cs_on;
    logic [TIME_W-1:0] cs_rd_off;
    logic [TIME_W-1:0] cs_wr_off;
    logic [TIME_W-1:0] adv_on;
    logic [TIME_W-1:0] adv_rd_off;
    logic [TIME_W-1:0] adv_wr_off;
    logic [TIME_W-1:0] oe_on;
    logic [TIME_W-1:0] oe_off;
    logic [TIME_W-1:0] we_on;
    logic [TIME_W-1:0] we_off;
    logic [TIME_W-1:0] rd_acc;
    logic [TIME_W-1:0] rd_cyc;
    logic [TIME_W-1:0] wr_cyc;
    logic              gap_same;
    logic              gap_diff;
    logic [GAP_W-1:0]  gap_len;
  } tcfg_t;

  function automatic logic in_win(input logic [TIME_W-1:0] c,
                                  input logic [TIME_W-1:0] on,
                                  input logic [TIME_W-1:0] off);
    return (c >= on) && (c < off);
  endfunction
endpackage

// File: rtl/asm_ctrl.sv
module asm_ctrl
  import asm_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  tcfg_t             cfg_i,
  output logic              active_o,
  output logic [TIME_W-1:0] cnt_o,
  output logic [TIME_W-1:0] len_o,
  output logic [CS_W-1:0]   cur_cs_o,
  output logic              cur_write_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [BE_W-1:0]   cur_be_o,
  output logic [DATA_W-1:0] cur_wdata_o
);
  localparam int RQ_W = CS_W + 1 + ADDR_W + BE_W + DATA_W;

  seq_st_e           state_q;
  logic [TIME_W-1:0] cnt_q;
  logic [GAP_W-1:0]  gcnt_q;
  logic [RQ_W-1:0]   cur_q, pend_q, req_vec;
  logic [TIME_W-1:0] cyc;
  logic              last, accept, gap_need;

  assign req_vec = {req_cs_i, req_write_i, req_addr_i, req_be_i, req_wdata_i};
  assign {cur_cs_o, cur_write_o, cur_addr_o, cur_be_o, cur_wdata_o} = cur_q;

  assign cyc   = cur_write_o ? cfg_i.wr_cyc : cfg_i.rd_cyc;
  assign len_o = (cyc == '0) ? TIME_W'(1) : cyc;
  assign last  = (state_q == ST_ACC) && (cnt_q == len_o - 1'b1);

  assign req_ready_o = (state_q == ST_IDLE) || last;
  assign accept      = req_valid_i && req_ready_o;
  // gap policy comes from the select whose access is finishing
  assign gap_need = accept && last && (cfg_i.gap_len != '0) &&
                    ((req_cs_i == cur_cs_o) ? cfg_i.gap_same : cfg_i.gap_diff);

  assign active_o = (state_q == ST_ACC);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gcnt_q  <= '0;
      cur_q   <= '0;
      pend_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_q   <= req_vec;
          cnt_q   <= '0;
          state_q <= ST_ACC;
        end
        ST_ACC: begin
          if (!last) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (gap_need) begin
            pend_q  <= req_vec;
            gcnt_q  <= cfg_i.gap_len;
            state_q <= ST_GAP;
          end else if (accept) begin
            cur_q <= req_vec;
            cnt_q <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (gcnt_q == GAP_W'(1)) begin
            cur_q   <= pend_q;
            cnt_q   <= '0;
            state_q <= ST_ACC;
          end else begin
            gcnt_q <= gcnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC) |-> (cnt_q < len_o));

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC && cnt_q != '0) |-> $stable(cur_addr_o));

  a_r8_gap_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/asm_strobe.sv
module asm_strobe
  import asm_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int BE_W   = 2,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              active_i,
  input  logic              write_i,
  input  logic [TIME_W-1:0] cnt_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [BE_W-1:0]   be_i,
  input  tcfg_t             cfg_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              adv_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [BE_W-1:0]   be_no,
  output logic              wdata_oe_o
);
  logic cs_win, adv_win, oe_win, we_win;

  always_comb begin
    cs_win  = in_win(cnt_i, cfg_i.cs_on,
                     write_i ? cfg_i.cs_wr_off : cfg_i.cs_rd_off);
    adv_win = in_win(cnt_i, cfg_i.adv_on,
                     write_i ? cfg_i.adv_wr_off : cfg_i.adv_rd_off);
    oe_win  = in_win(cnt_i, cfg_i.oe_on, cfg_i.oe_off);
    we_win  = in_win(cnt_i, cfg_i.we_on, cfg_i.we_off);
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign cs_no[k] = !(active_i && cs_win && (cs_i == CS_W'(k)));
  end

  assign adv_no     = !(active_i && adv_win);
  assign oe_no      = !(active_i && !write_i && oe_win);
  assign we_no      = !(active_i && write_i && we_win);
  assign be_no      = ~(be_i & {BE_W{active_i}});
  assign wdata_oe_o = active_i && write_i;
endmodule

// File: rtl/asm_rd_capture.sv
module asm_rd_capture
  import asm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              write_i,
  input  logic [TIME_W-1:0] cnt_i,
  input  logic [TIME_W-1:0] rd_acc_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic take;
  assign take = active_i && !write_i && (cnt_i == rd_acc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= take;
      if (take) rd_data_o <= mem_rdata_i;
    end
  end

  a_r9_valid_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(active_i && !write_i));
endmodule

// File: rtl/async_mem_seq.sv
module async_mem_seq
  import asm_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_write_i,
  input  logic [CS_W-1:0]                req_cs_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [BE_W-1:0]                req_be_i,
  input  logic [DATA_W-1:0]              req_wdata_i,
  output logic                           rd_valid_o,
  output logic [DATA_W-1:0]              rd_data_o,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_cs_on_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_cs_rd_off_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_cs_wr_off_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_adv_on_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_adv_rd_off_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_adv_wr_off_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_oe_on_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_oe_off_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_we_on_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_we_off_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_rd_acc_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_rd_cyc_i,
  input  logic [NUM_CS-1:0][TIME_W-1:0]  cfg_wr_cyc_i,
  input  logic [NUM_CS-1:0]              cfg_gap_same_i,
  input  logic [NUM_CS-1:0]              cfg_gap_diff_i,
  input  logic [NUM_CS-1:0][GAP_W-1:0]   cfg_gap_len_i,
  output logic [NUM_CS-1:0]              mem_cs_no,
  output logic                           mem_adv_no,
  output logic                           mem_oe_no,
  output logic                           mem_we_no,
  output logic [BE_W-1:0]                mem_be_no,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic [DATA_W-1:0]              mem_wdata_o,
  output logic                           mem_wdata_oe_o,
  input  logic [DATA_W-1:0]              mem_rdata_i
);
  tcfg_t             cfg_tab [NUM_CS];
  tcfg_t             cur_cfg;
  logic              active, cur_write;
  logic [TIME_W-1:0] cnt, len;
  logic [CS_W-1:0]   cur_cs;
  logic [BE_W-1:0]   cur_be;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cfg
    always_comb begin
      cfg_tab[k].cs_on      = cfg_cs_on_i[k];
      cfg_tab[k].cs_rd_off  = cfg_cs_rd_off_i[k];
      cfg_tab[k].cs_wr_off  = cfg_cs_wr_off_i[k];
      cfg_tab[k].adv_on     = cfg_adv_on_i[k];
      cfg_tab[k].adv_rd_off = cfg_adv_rd_off_i[k];
      cfg_tab[k].adv_wr_off = cfg_adv_wr_off_i[k];
      cfg_tab[k].oe_on      = cfg_oe_on_i[k];
      cfg_tab[k].oe_off     = cfg_oe_off_i[k];
      cfg_tab[k].we_on      = cfg_we_on_i[k];
      cfg_tab[k].we_off     = cfg_we_off_i[k];
      cfg_tab[k].rd_acc     = cfg_rd_acc_i[k];
      cfg_tab[k].rd_cyc     = cfg_rd_cyc_i[k];
      cfg_tab[k].wr_cyc     = cfg_wr_cyc_i[k];
      cfg_tab[k].gap_same   = cfg_gap_same_i[k];
      cfg_tab[k].gap_diff   = cfg_gap_diff_i[k];
      cfg_tab[k].gap_len    = cfg_gap_len_i[k];
    end
  end

  assign cur_cfg = cfg_tab[cur_cs];

  asm_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_cs_i    (req_cs_i),
    .req_addr_i  (req_addr_i),
    .req_be_i    (req_be_i),
    .req_wdata_i (req_wdata_i),
    .cfg_i       (cur_cfg),
    .active_o    (active),
    .cnt_o       (cnt),
    .len_o       (len),
    .cur_cs_o    (cur_cs),
    .cur_write_o (cur_write),
    .cur_addr_o  (mem_addr_o),
    .cur_be_o    (cur_be),
    .cur_wdata_o (mem_wdata_o)
  );

  asm_strobe #(.NUM_CS(NUM_CS), .BE_W(BE_W)) u_strobe (
    .active_i   (active),
    .write_i    (cur_write),
    .cnt_i      (cnt),
    .cs_i       (cur_cs),
    .be_i       (cur_be),
    .cfg_i      (cur_cfg),
    .cs_no      (mem_cs_no),
    .adv_no     (mem_adv_no),
    .oe_no      (mem_oe_no),
    .we_no      (mem_we_no),
    .be_no      (mem_be_no),
    .wdata_oe_o (mem_wdata_oe_o)
  );

  asm_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .write_i     (cur_write),
    .cnt_i       (cnt),
    .rd_acc_i    (cur_cfg.rd_acc),
    .mem_rdata_i (mem_rdata_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  a_r4_oe_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  a_r6_quiet_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (&mem_cs_no && mem_adv_no && mem_oe_no && mem_we_no &&
                 &mem_be_no && !mem_wdata_oe_o));

  a_r10_len_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cnt != '0) |-> $stable(len));
endmodule

// File: tb/tb_async_mem_seq.sv
`timescale 1ns/1ps
module tb_async_mem_seq;
  typedef struct {
    int          cs;
    bit          w;
    logic [10:0] a;
    logic [1:0]  be;
    logic [15:0] wd;
  } req_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [10:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, mem_rdata = '0;
  logic [7:0][4:0] cs_on, cs_rd_off, cs_wr_off, adv_on, adv_rd_off, adv_wr_off;
  logic [7:0][4:0] oe_on, oe_off, we_on, we_off, rd_acc, rd_cyc, wr_cyc;
  logic [7:0]      gap_same, gap_diff;
  logic [7:0][3:0] gap_len;

  logic        req_ready, rd_valid, mem_adv_n, mem_oe_n, mem_we_n, mem_wdata_oe;
  logic [15:0] rd_data, mem_wdata;
  logic [7:0]  mem_cs_n;
  logic [1:0]  mem_be_n;
  logic [10:0] mem_addr;

  async_mem_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_cs_i(req_cs), .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .cfg_cs_on_i(cs_on), .cfg_cs_rd_off_i(cs_rd_off), .cfg_cs_wr_off_i(cs_wr_off),
    .cfg_adv_on_i(adv_on), .cfg_adv_rd_off_i(adv_rd_off), .cfg_adv_wr_off_i(adv_wr_off),
    .cfg_oe_on_i(oe_on), .cfg_oe_off_i(oe_off), .cfg_we_on_i(we_on), .cfg_we_off_i(we_off),
    .cfg_rd_acc_i(rd_acc), .cfg_rd_cyc_i(rd_cyc), .cfg_wr_cyc_i(wr_cyc),
    .cfg_gap_same_i(gap_same), .cfg_gap_diff_i(gap_diff), .cfg_gap_len_i(gap_len),
    .mem_cs_no(mem_cs_n), .mem_adv_no(mem_adv_n), .mem_oe_no(mem_oe_n), .mem_we_no(mem_we_n),
    .mem_be_no(mem_be_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_wdata_oe_o(mem_wdata_oe), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_err = 0, seed = 0;
  bit exp_rv = 1'b0;
  logic [15:0] exp_rd = '0;
  string cs_tag = "R2";
  req_t sq [4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  function automatic bit win(input int c, input int on, input int off);
    return (c >= on) && (c < off);
  endfunction

  function automatic int eff(input req_t r);
    int c = r.w ? int'(wr_cyc[r.cs]) : int'(rd_cyc[r.cs]);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int gapc(input req_t p, input req_t n);
    bit en = (p.cs == n.cs) ? gap_same[p.cs] : gap_diff[p.cs];
    return en ? int'(gap_len[p.cs]) : 0;
  endfunction

  task automatic chk_rv();
    chk("R9", {31'd0, rd_valid}, {31'd0, exp_rv});
    if (exp_rv) chk("R9", {16'd0, rd_data}, {16'd0, exp_rd});
  endtask

  task automatic drive(input req_t r);
    req_valid = 1'b1; req_write = r.w; req_cs = 3'(r.cs);
    req_addr = r.a; req_be = r.be; req_wdata = r.wd;
  endtask

  task automatic quiet(input string tag, input bit rdy);
    chk(tag, {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_be_n, mem_wdata_oe},
        {8'hFF, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
    chk("R10", {31'd0, req_ready}, {31'd0, rdy});
    chk_rv();
    exp_rv = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  // sampling at negedge of count c of access r
  task automatic body(input req_t r, input bit chain, input req_t nx);
    int L = eff(r);
    for (int c = 0; c < L; c++) begin
      logic [7:0] ecs = 8'hFF;
      int csoff = r.w ? int'(cs_wr_off[r.cs]) : int'(cs_rd_off[r.cs]);
      int adoff = r.w ? int'(adv_wr_off[r.cs]) : int'(adv_rd_off[r.cs]);
      if (win(c, cs_on[r.cs], csoff)) ecs[r.cs] = 1'b0;
      chk(cs_tag, {24'd0, mem_cs_n}, {24'd0, ecs});
      chk("R3", {31'd0, mem_adv_n}, {31'd0, !win(c, adv_on[r.cs], adoff)});
      chk("R4", {30'd0, mem_oe_n, mem_we_n},
          {30'd0, !(!r.w && win(c, oe_on[r.cs], oe_off[r.cs])),
                  !(r.w && win(c, we_on[r.cs], we_off[r.cs]))});
      chk("R4", {15'd0, mem_wdata_oe, r.w ? mem_wdata : 16'd0},
          {15'd0, r.w, r.w ? r.wd : 16'd0});
      chk(cs_tag == "R7" ? "R7" : "R5", {19'd0, mem_be_n, mem_addr}, {19'd0, ~r.be, r.a});
      chk("R10", {31'd0, req_ready}, {31'd0, c == L - 1});
      chk_rv();
      mem_rdata = 16'(16'h3C00 + seed * 37 + c * 5);
      exp_rv = !r.w && (c == int'(rd_acc[r.cs]));
      exp_rd = mem_rdata;
      if (chain && c == L - 1) drive(nx);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
    end
    seed++;
  endtask

  task automatic run_seq(input int n);
    drive(sq[0]);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit ch = (i < n - 1);
      body(sq[i], ch, sq[ch ? i + 1 : i]);
      if (ch) for (int g = 0; g < gapc(sq[i], sq[i + 1]); g++) quiet("R8", 1'b0);
    end
    quiet("R6", 1'b1);
  endtask

  task automatic set_all(input int a, input int b, input int cyc);
    for (int k = 0; k < 8; k++) begin
      cs_on[k] = 5'(a); cs_rd_off[k] = 5'(b); cs_wr_off[k] = 5'(b + 1);
      adv_on[k] = 5'((a + 1) % 3); adv_rd_off[k] = 5'(a + 2); adv_wr_off[k] = 5'(b);
      oe_on[k] = 5'(a % 2); oe_off[k] = 5'(b + 1); we_on[k] = 5'(a); we_off[k] = 5'(b);
      rd_acc[k] = 5'(b); rd_cyc[k] = 5'(cyc); wr_cyc[k] = 5'(cyc);
      gap_same[k] = 1'b0; gap_diff[k] = 1'b0; gap_len[k] = 4'd0;
    end
  endtask

  function automatic req_t mk(input int cs, input bit w, input int a);
    req_t r;
    r.cs = cs; r.w = w; r.a = 11'(a * 97 + 5); r.be = 2'(a + cs);
    r.wd = 16'(16'hA500 ^ (a * 1021));
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cycs [5] = '{0, 1, 2, 4, 7};
    set_all(0, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset values, while held and after release
    chk("R1", {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_be_n, mem_wdata_oe, req_ready, rd_valid},
        {8'hFF, 3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_be_n, mem_wdata_oe, req_ready, rd_valid},
        {8'hFF, 3'b111, 2'b11, 1'b0, 1'b1, 1'b0});

    // single-access sweep: R2 R3 R4 R5 R6 R9 R10
    foreach (cycs[i]) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b <= cycs[i] + 2; b++) begin
          set_all(a, b, cycs[i]);
          for (int w = 0; w < 2; w++) begin
            sq[0] = mk((a * 3 + b + w) % 8, w[0], a * 16 + b + w + i);
            run_seq(1);
          end
        end
      end
    end

    // R7: chained, strobes held across boundaries
    set_all(0, 4, 4);
    for (int k = 0; k < 8; k++) begin
      cs_wr_off[k] = 5'd4; adv_rd_off[k] = 5'd4; adv_wr_off[k] = 5'd4;
      oe_on[k] = 5'd0; oe_off[k] = 5'd4; we_on[k] = 5'd0; we_off[k] = 5'd4; rd_acc[k] = 5'd3;
    end
    cs_tag = "R7";
    sq[0] = mk(1, 1'b0, 1); sq[1] = mk(1, 1'b0, 2); sq[2] = mk(1, 1'b1, 3); sq[3] = mk(2, 1'b0, 4);
    run_seq(4);
    sq[0] = mk(6, 1'b1, 5); sq[1] = mk(6, 1'b1, 6); sq[2] = mk(7, 1'b1, 7);
    run_seq(3);
    cs_tag = "R2";

    // R8: gap policies per finishing chip select
    set_all(1, 2, 3);
    for (int k = 0; k < 8; k++) rd_acc[k] = 5'd2;
    gap_same[3] = 1'b1; gap_len[3] = 4'd3;
    gap_diff[4] = 1'b1; gap_len[4] = 4'd2;
    gap_same[5] = 1'b1; gap_diff[5] = 1'b1; gap_len[5] = 4'd0;
    sq[0] = mk(3, 1'b0, 8); sq[1] = mk(3, 1'b1, 9); sq[2] = mk(4, 1'b0, 10); sq[3] = mk(5, 1'b1, 11);
    run_seq(4);
    sq[0] = mk(4, 1'b0, 12); sq[1] = mk(4, 1'b0, 13); sq[2] = mk(5, 1'b0, 14); sq[3] = mk(5, 1'b0, 15);
    run_seq(4);
    sq[0] = mk(3, 1'b1, 16); sq[1] = mk(3, 1'b0, 17);
    run_seq(2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule